// File: doc/BRIEF.md
# Flash Block Write-Protection Unit

This block guards the program and erase path of a 64 KB flash space. It holds one 8-bit protect code, which software reads and writes over a simple memory-mapped register bus. The code is decoded into a protected window that starts on a 512-byte page boundary and runs to the top of the address space.

Each program or erase request presents a 16-bit target address. One cycle later the block returns either a grant pulse, which forwards the request to the flash controller, or a deny pulse, which drops it.

Two codes have fixed meanings. Any code whose window would begin below the flash base locks the whole array. The all-ones code switches off the window. A small top region holds the option byte and the vector bytes, and it stays locked under every code. A combinational flag shows the protection state of the current request address at all times.

Top module: `flash_guard`

## Requirements
- R1: After reset the stored code is 0x00, so every address from the flash base up to 0xFFFF is protected.
- R2: A write with `busWr` high and `busAddr` equal to REG_ADDR (default 0xFE09) stores `busWdata` on that clock edge, and the new code takes effect from the next cycle. A read at REG_ADDR returns the stored 8 bits unchanged. A read at any other address returns 0x00.
- R3: For codes other than 0xFF, the window start is {code[7:1], nine zero bits}. An address is protected when it is at or above that start and at or above the flash base, and it is unprotected when it is below the start.
- R4: Code bit 0 has no effect unless the whole code is 0xFF. For example, 0x0A and 0x0B protect the same addresses.
- R5: Codes whose computed start lies below FLASH_BASE (0x00 to 0x09 with the default base of 0x0A00) protect the whole array from FLASH_BASE to 0xFFFF.
- R6: Code 0xFF leaves every address from FLASH_BASE up to 0xFFCE unprotected.
- R7: Addresses 0xFFCF to 0xFFFF are protected under every code.
- R8: Addresses below FLASH_BASE are never protected.
- R9: A request presented with `reqValid` high at a clock edge produces, in the following cycle only, `reqDeny`=1 if its address is protected and `reqGrant`=1 otherwise. Both outputs are 0 in cycles without a request, and they are never high together.
- R10: A write to any address other than REG_ADDR leaves the stored code and the protection map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Register bus address |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data (combinational) |
| reqValid | input | 1 | Program/erase request valid |
| reqAddr | input | 16 | Program/erase target address |
| protHit | output | 1 | Current `reqAddr` lies in the protected set (combinational) |
| reqDeny | output | 1 | One-cycle pulse: the request was blocked |
| reqGrant | output | 1 | One-cycle pulse: the request is forwarded to the flash controller |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit code, the register at 0xFE09, the flash base at 0x0A00 and the locked top region starting at 0xFFCF. With the base at 0x0A00, the low codes 0x00 to 0x09 compute starts below the array, so the clamp-to-base path is exercised. All 256 codes are swept against the addresses either side of the flash base, either side of each code's page start, and either side of the top region. This reaches every odd/even code pair, the all-ones code and the clamp path.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic regWrite;  // store busWdata into the protect code
    logic regRead;   // drive the protect code onto busRdata
    logic reqLatch;  // register the allow/deny decision for reqAddr
  } guardStrobes_t;

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE09
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              reqValid,
  output guardStrobes_t     strb
);

  logic regSel;

  assign regSel = (busAddr == REG_ADDR);

  always_comb begin
    strb          = '0;
    strb.regWrite = busWr && regSel;
    strb.regRead  = busRd && regSel;
    strb.reqLatch = reqValid;
  end

  // R10
  foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr != REG_ADDR) |-> !strb.regWrite);

endmodule

// File: rtl/guard_datapath.sv
module guard_datapath
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CODE_W = 8,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h0A00,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFCF
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strb,
  input  logic [CODE_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [CODE_W-1:0] busRdata,
  output logic              protHit,
  output logic              reqDeny,
  output logic              reqGrant
);

  // The code's upper CODE_W-1 bits become the top address bits of the window start
  localparam int unsigned PAGE_BITS = ADDR_W - (CODE_W - 1);
  localparam logic [CODE_W-1:0] OFF_CODE = '1;

  logic [CODE_W-1:0] protReg;
  logic [ADDR_W-1:0] rawStart;
  logic [ADDR_W-1:0] winStart;
  logic              protOff;
  logic              inVec;
  logic              inFlash;
  logic              inWindow;

  // Protect code register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      protReg <= '0;
    end else if (strb.regWrite) begin
      protReg <= busWdata;
    end
  end

  assign busRdata = strb.regRead ? protReg : '0;

  // Window decode
  always_comb begin
    rawStart = {protReg[CODE_W-1:1], {PAGE_BITS{1'b0}}};
    winStart = (rawStart < FLASH_BASE) ? FLASH_BASE : rawStart;
    protOff  = (protReg == OFF_CODE);
    inVec    = (reqAddr >= VEC_BASE);
    inFlash  = (reqAddr >= FLASH_BASE);
    inWindow = !protOff && inFlash && (reqAddr >= winStart);
    protHit  = inVec || inWindow;
  end

  // Registered allow/deny decision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqDeny  <= 1'b0;
      reqGrant <= 1'b0;
    end else begin
      reqDeny  <= strb.reqLatch && protHit;
      reqGrant <= strb.reqLatch && !protHit;
    end
  end

  // R2
  code_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.regWrite |=> (protReg == $past(busWdata)));

  // R7
  vector_always_denied_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reqLatch && reqAddr >= VEC_BASE) |=> reqDeny);

  // R8
  below_base_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reqLatch && reqAddr < FLASH_BASE) |=> reqGrant);

  // R9
  deny_grant_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqDeny && reqGrant));

  // R9
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.reqLatch |=> (!reqDeny && !reqGrant));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CODE_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE09,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h0A00,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFCF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CODE_W-1:0] busWdata,
  output logic [CODE_W-1:0] busRdata,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              protHit,
  output logic              reqDeny,
  output logic              reqGrant
);

  guardStrobes_t strb;

  guard_ctrl #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .reqValid (reqValid),
    .strb     (strb)
  );

  guard_datapath #(
    .ADDR_W     (ADDR_W),
    .CODE_W     (CODE_W),
    .FLASH_BASE (FLASH_BASE),
    .VEC_BASE   (VEC_BASE)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .reqAddr  (reqAddr),
    .busRdata (busRdata),
    .protHit  (protHit),
    .reqDeny  (reqDeny),
    .reqGrant (reqGrant)
  );

endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        protHit;
  logic        reqDeny;
  logic        reqGrant;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_guard u0 (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .protHit  (protHit),
    .reqDeny  (reqDeny),
    .reqGrant (reqGrant)
  );

  // Reference model built from the requirements
  function automatic bit expProt(input logic [7:0] c, input logic [15:0] a);
    if (a >= 16'hFFCF) return 1'b1;  // R7
    if (a < 16'h0A00) return 1'b0;   // R8
    if (c == 8'hFF) return 1'b0;     // R6
    if (c <= 8'h09) return 1'b1;     // R5
    return a >= {c[7:1], 9'b0};      // R3, R4
  endfunction

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input logic [15:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1;
    d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic probe(input string req, input logic [7:0] c, input logic [15:0] a);
    reqAddr = a;
    #1;
    check(req, protHit, expProt(c, a));
  endtask

  task automatic testReset();
    logic [7:0] d;
    readReg(16'hFE09, d);
    check("R1 reset code", d, 8'h00);
    probe("R1 base locked", 8'h00, 16'h0A00);
    probe("R1 mid locked", 8'h00, 16'h8000);
  endtask

  task automatic testRegAccess();
    logic [7:0] d;
    writeReg(16'hFE09, 8'h5A);
    readReg(16'hFE09, d);
    check("R2 readback", d, 8'h5A);
    readReg(16'hFE08, d);
    check("R2 foreign read zero", d, 8'h00);
    writeReg(16'hFE08, 8'hFF);
    readReg(16'hFE09, d);
    check("R10 foreign write ignored", d, 8'h5A);
    probe("R10 map unchanged", 8'h5A, 16'h5A00);
    probe("R10 map unchanged below", 8'h5A, 16'h59FF);
  endtask

  task automatic testBit0();
    logic h0, h1;
    writeReg(16'hFE09, 8'h0C);
    reqAddr = 16'h0BFF; #1; h0 = protHit;
    writeReg(16'hFE09, 8'h0D);
    reqAddr = 16'h0BFF; #1; h1 = protHit;
    check("R4 odd equals even below", h1, h0);
    reqAddr = 16'h0C00; #1;
    check("R4 odd code start", protHit, 1);
  endtask

  task automatic testLowCodes();
    for (int c = 0; c <= 9; c++) begin
      writeReg(16'hFE09, 8'(c));
      probe("R5 base locked", 8'(c), 16'h0A00);
      probe("R5 base-1 open", 8'(c), 16'h09FF);
    end
  endtask

  task automatic testOffCode();
    writeReg(16'hFE09, 8'hFF);
    probe("R6 base open", 8'hFF, 16'h0A00);
    probe("R6 below vectors open", 8'hFF, 16'hFFCE);
    probe("R7 option byte locked", 8'hFF, 16'hFFCF);
    probe("R7 top locked", 8'hFF, 16'hFFFF);
  endtask

  task automatic testSweep();
    for (int c = 0; c < 256; c++) begin
      logic [15:0] s;
      s = {8'(c) >> 1, 9'b0};
      writeReg(16'hFE09, 8'(c));
      probe("R8 sweep below base", 8'(c), 16'h09FF);
      probe("R3 sweep base", 8'(c), 16'h0A00);
      if (s != 0) probe("R3 sweep start-1", 8'(c), s - 16'd1);
      probe("R3 sweep start", 8'(c), s);
      probe("R3 sweep page end", 8'(c), s + 16'h01FF);
      probe("R3 sweep FFCE", 8'(c), 16'hFFCE);
      probe("R7 sweep FFCF", 8'(c), 16'hFFCF);
      probe("R7 sweep FFFF", 8'(c), 16'hFFFF);
    end
  endtask

  task automatic request(input string req, input logic [15:0] a, input bit expDeny);
    @(negedge clk);
    reqAddr = a; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " deny"}, reqDeny, expDeny);
    check({req, " grant"}, reqGrant, !expDeny);
    @(negedge clk);
    check("R9 deny one cycle", reqDeny, 0);
    check("R9 grant one cycle", reqGrant, 0);
  endtask

  task automatic testRequests();
    writeReg(16'hFE09, 8'h80);
    request("R9 protected", 16'h8000, 1'b1);
    request("R9 open", 16'h7FFF, 1'b0);
    request("R9 vector", 16'hFFE0, 1'b1);
    request("R9 below base", 16'h0100, 1'b0);
    writeReg(16'hFE09, 8'hFF);
    request("R9 off code vector", 16'hFFCF, 1'b1);
    request("R9 off code open", 16'hC000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegAccess();
    testBit0();
    testLowCodes();
    testOffCode();
    testSweep();
    testRequests();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

endmodule